// File: doc/BRIEF.md
# Isochronous Latency Deadline Monitor

This block passively observes an isochronous target. It sees a period-start pulse, request strobes tagged read or write, and data-start strobes tagged read or write. It checks that the data for every request begins within a configured latency L, counted in whole isochronous periods. It also checks that the data in each stream comes back in request order.

Each stream (read and write) keeps its own in-order queue of outstanding requests. A queue entry holds the request's identifier and the period in which the request was issued. The two streams are independent, so a write transfer may overtake an older read without any complaint. Every fault is reported on a sticky per-stream flag that only reset clears. Index 0 of each flag vector is the read stream and index 1 is the write stream.

Both strobe inputs are valid-only observation channels, and the block never pushes back. There is no ready signal: any event presented with its valid high is taken in that cycle. A request the monitor cannot store is reported, not stalled.

Top module: `iso_deadline_monitor`

## Requirements
- R1: After reset all eight flag outputs are low. The period counter restarts at period 0.
- R2: A request issued in period k whose data-start occurs in any cycle of periods k to k+L raises no deadline miss.
- R3: If the head request issued in period k is still pending when period k+L ends, the deadline_miss bit for that stream is set. Period k+L ends at the period_start pulse that opens period k+L+1, and the bit is visible in the following cycle.
- R4: With L=0, data must start in the same period as its request. A request whose data has not started when the next period begins raises a miss.
- R5: An event in the same cycle as period_start belongs to the new period. A data-start for an overdue head in that cycle still raises a miss.
- R6: Within a stream, every data-start must carry the identifier of that stream's oldest outstanding request. On a mismatch, order_err for that stream is set and the head entry is still retired.
- R7: No order is required between the streams. A write data-start that overtakes earlier reads raises no flag.
- R8: A data-start for a stream with an empty queue sets underflow_err for that stream. A request in the same cycle does not prevent this.
- R9: Each queue holds MAX_REQ*(MAX_LAT+1) entries (30 by default). A request while the queue is full, with no data-start for that stream in the same cycle, sets overflow_err and is not tracked.
- R10: All flags are sticky until reset. A fault in one stream never sets a flag of the other stream.
- R11: A lat_cfg value above MAX_LAT is treated as MAX_LAT.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| period_start | input | 1 | One-cycle pulse in the first cycle of each isochronous period |
| lat_cfg | input | 3 | Contracted latency L in periods (0..5) |
| req_valid | input | 1 | Request strobe |
| req_is_write | input | 1 | Request stream: 0 read, 1 write |
| req_id | input | 4 | Request identifier |
| xfer_valid | input | 1 | Data-start strobe |
| xfer_is_write | input | 1 | Data-start stream: 0 read, 1 write |
| xfer_id | input | 4 | Identifier of the request whose data starts |
| deadline_miss | output | 2 | Sticky deadline miss per stream |
| order_err | output | 2 | Sticky in-stream order violation per stream |
| underflow_err | output | 2 | Sticky data-start with empty queue per stream |
| overflow_err | output | 2 | Sticky request dropped on full queue per stream |

## Verification
The deadline check is tried in several ways. Data arrives on the last allowed period, data is left pending one period too long, L is zero, and data-start coincides with a period pulse. Together these fix the exact boundary and show which period a same-cycle event belongs to. Interleaved read and write identifiers, delivered with the writes overtaking and then with reads out of order, separate the per-stream order check from any cross-stream ordering. A queue is filled to its depth plus one and then drained one beyond. This shows that the extra request was dropped rather than stored. A clamped oversized latency setting and a mixed-stream fault sequence confirm that the flags are independent and sticky.

// File: rtl/iso_mon_pkg.sv
package iso_mon_pkg;
  typedef enum logic {
    STRM_RD = 1'b0,
    STRM_WR = 1'b1
  } strm_e;

  localparam int NUM_STRM = 2;

  // Ring pointer advance with wrap at a given last index.
  function automatic int unsigned ring_next(input int unsigned ptr, input int unsigned last);
    return (ptr == last) ? 0 : ptr + 1;
  endfunction
endpackage

// File: rtl/iso_period_ctr.sv
module iso_period_ctr #(
  parameter int PER_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  output logic [PER_W-1:0] cur_per,
  output logic [PER_W-1:0] nxt_per
);
  always_ff @(posedge clk) begin
    if (!rst_n)    cur_per <= '0;
    else if (tick) cur_per <= cur_per + 1'b1;
  end

  assign nxt_per = cur_per + 1'b1;

  // R3
  per_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(cur_per));
endmodule

// File: rtl/iso_tag_fifo.sv
module iso_tag_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 30
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic             pop,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout,
  output logic             empty,
  output logic             full
);
  import iso_mon_pkg::*;

  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wr_ptr, rd_ptr;
  logic [CW-1:0]    count;
  logic             do_push, do_pop;

  assign empty   = (count == '0);
  assign full    = (count == CW'(DEPTH));
  assign do_pop  = pop && !empty;
  assign do_push = push && (!full || do_pop);
  assign dout    = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= AW'(ring_next(32'(wr_ptr), DEPTH - 1));
      if (do_pop)  rd_ptr <= AW'(ring_next(32'(rd_ptr), DEPTH - 1));
      unique case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  // R9
  full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push && !pop) |=> $stable(count));

  // R8
  empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && pop && !push) |=> (count == '0));
endmodule

// File: rtl/iso_stream_tracker.sv
module iso_stream_tracker #(
  parameter int DEPTH = 30,
  parameter int PER_W = 4,
  parameter int ID_W  = 4,
  parameter int LAT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             period_start,
  input  logic [PER_W-1:0] cur_per,
  input  logic [PER_W-1:0] req_per,
  input  logic [LAT_W-1:0] lat,
  input  logic             req_v,
  input  logic [ID_W-1:0]  req_id,
  input  logic             xfer_v,
  input  logic [ID_W-1:0]  xfer_id,
  output logic             miss_q,
  output logic             order_q,
  output logic             unf_q,
  output logic             ovf_q
);
  localparam int EW = ID_W + PER_W;

  logic [EW-1:0]    head;
  logic [ID_W-1:0]  head_id;
  logic [PER_W-1:0] head_per, elapsed;
  logic             empty, full;
  logic             miss_evt, ord_evt, unf_evt, ovf_evt;

  iso_tag_fifo #(.WIDTH(EW), .DEPTH(DEPTH)) fifo_i (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (req_v),
    .pop   (xfer_v),
    .din   ({req_id, req_per}),
    .dout  (head),
    .empty (empty),
    .full  (full)
  );

  assign head_id  = head[EW-1:PER_W];
  assign head_per = head[PER_W-1:0];
  assign elapsed  = cur_per - head_per;

  assign miss_evt = period_start && !empty && (elapsed >= PER_W'(lat));
  assign ord_evt  = xfer_v && !empty && (head_id != xfer_id);
  assign unf_evt  = xfer_v && empty;
  assign ovf_evt  = req_v && full && !xfer_v;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      miss_q  <= 1'b0;
      order_q <= 1'b0;
      unf_q   <= 1'b0;
      ovf_q   <= 1'b0;
    end else begin
      miss_q  <= miss_q  | miss_evt;
      order_q <= order_q | ord_evt;
      unf_q   <= unf_q   | unf_evt;
      ovf_q   <= ovf_q   | ovf_evt;
    end
  end

  // R10
  sticky_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    miss_q |=> miss_q);

  // R6
  order_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(order_q) |-> $past(xfer_v));

  // R3
  miss_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(miss_q) |-> $past(period_start));
endmodule

// File: rtl/iso_deadline_monitor.sv
module iso_deadline_monitor #(
  parameter int MAX_REQ = 5,
  parameter int MAX_LAT = 5,
  parameter int ID_W    = 4
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              period_start,
  input  logic [$clog2(MAX_LAT+1)-1:0]      lat_cfg,
  input  logic                              req_valid,
  input  logic                              req_is_write,
  input  logic [ID_W-1:0]                   req_id,
  input  logic                              xfer_valid,
  input  logic                              xfer_is_write,
  input  logic [ID_W-1:0]                   xfer_id,
  output logic [iso_mon_pkg::NUM_STRM-1:0]  deadline_miss,
  output logic [iso_mon_pkg::NUM_STRM-1:0]  order_err,
  output logic [iso_mon_pkg::NUM_STRM-1:0]  underflow_err,
  output logic [iso_mon_pkg::NUM_STRM-1:0]  overflow_err
);
  import iso_mon_pkg::*;

  localparam int LAT_W = $clog2(MAX_LAT + 1);
  localparam int PER_W = $clog2(MAX_LAT + 2) + 1;
  localparam int DEPTH = MAX_REQ * (MAX_LAT + 1);

  logic [PER_W-1:0] cur_per, nxt_per, req_per;
  logic [LAT_W-1:0] lat_eff;

  iso_period_ctr #(.PER_W(PER_W)) per_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (period_start),
    .cur_per (cur_per),
    .nxt_per (nxt_per)
  );

  assign req_per = period_start ? nxt_per : cur_per;
  assign lat_eff = (lat_cfg > LAT_W'(MAX_LAT)) ? LAT_W'(MAX_LAT) : lat_cfg;

  for (genvar s = 0; s < NUM_STRM; s++) begin : g_strm
    logic rv, xv;
    assign rv = req_valid  && (req_is_write  == 1'(s));
    assign xv = xfer_valid && (xfer_is_write == 1'(s));

    iso_stream_tracker #(
      .DEPTH (DEPTH),
      .PER_W (PER_W),
      .ID_W  (ID_W),
      .LAT_W (LAT_W)
    ) trk_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .period_start (period_start),
      .cur_per      (cur_per),
      .req_per      (req_per),
      .lat          (lat_eff),
      .req_v        (rv),
      .req_id       (req_id),
      .xfer_v       (xv),
      .xfer_id      (xfer_id),
      .miss_q       (deadline_miss[s]),
      .order_q      (order_err[s]),
      .unf_q        (underflow_err[s]),
      .ovf_q        (overflow_err[s])
    );
  end

  // R10
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overflow_err[0] |=> overflow_err[0]);
endmodule

// File: tb/iso_deadline_monitor_tb.sv
module iso_deadline_monitor_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 30;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       period_start = 1'b0;
  logic [2:0] lat_cfg = 3'd2;
  logic       req_valid = 1'b0, req_is_write = 1'b0;
  logic [3:0] req_id = '0;
  logic       xfer_valid = 1'b0, xfer_is_write = 1'b0;
  logic [3:0] xfer_id = '0;
  logic [1:0] deadline_miss, order_err, underflow_err, overflow_err;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  iso_deadline_monitor #(.MAX_REQ(5), .MAX_LAT(5), .ID_W(4)) dut_i (
    .clk(clk), .rst_n(rst_n), .period_start(period_start), .lat_cfg(lat_cfg),
    .req_valid(req_valid), .req_is_write(req_is_write), .req_id(req_id),
    .xfer_valid(xfer_valid), .xfer_is_write(xfer_is_write), .xfer_id(xfer_id),
    .deadline_miss(deadline_miss), .order_err(order_err),
    .underflow_err(underflow_err), .overflow_err(overflow_err)
  );

  // Flag bits: [0]miss rd [1]miss wr [2]ord rd [3]ord wr [4]unf rd [5]unf wr [6]ovf rd [7]ovf wr
  function automatic logic [7:0] flags();
    return {overflow_err, underflow_err, order_err, deadline_miss};
  endfunction

  // Monitor: pops one expectation per cycle, just after the edge that registered it.
  always @(posedge clk) begin
    #1;
    if (exp_q.size() > 0) begin
      logic [7:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (flags() !== e) begin
        failures++;
        $display("FAIL %s: flags actual=%b expected=%b", t, flags(), e);
      end
    end
  end

  task automatic step(input bit ps, input bit rv, input bit rw, input logic [3:0] rid,
                      input bit xv, input bit xw, input logic [3:0] xid,
                      input logic [7:0] e, input string t);
    @(negedge clk);
    period_start = ps; req_valid = rv; req_is_write = rw; req_id = rid;
    xfer_valid = xv; xfer_is_write = xw; xfer_id = xid;
    exp_q.push_back(e);
    tag_q.push_back(t);
  endtask

  task automatic tick(input logic [7:0] e, input string t);
    step(1, 0, 0, 0, 0, 0, 0, e, t);
  endtask
  task automatic req(input bit w, input logic [3:0] id, input logic [7:0] e, input string t);
    step(0, 1, w, id, 0, 0, 0, e, t);
  endtask
  task automatic xfer(input bit w, input logic [3:0] id, input logic [7:0] e, input string t);
    step(0, 0, 0, 0, 1, w, id, e, t);
  endtask
  task automatic idle(input logic [7:0] e, input string t);
    step(0, 0, 0, 0, 0, 0, 0, e, t);
  endtask

  task automatic do_reset(input logic [2:0] lat);
    @(negedge clk);
    rst_n = 1'b0; lat_cfg = lat;
    period_start = 0; req_valid = 0; xfer_valid = 0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    checks++;
    if (flags() !== 8'h00) begin
      failures++;
      $display("FAIL R1: flags after reset actual=%b expected=%b", flags(), 8'h00);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // R2: data on last allowed period, L=2
    do_reset(3'd2);
    req(0, 4'd1, 8'h00, "R2");
    tick(8'h00, "R2");
    tick(8'h00, "R2");
    xfer(0, 4'd1, 8'h00, "R2");
    tick(8'h00, "R2");
    idle(8'h00, "R2");

    // R3 + R10: write left pending past k+L
    do_reset(3'd2);
    req(1, 4'd3, 8'h00, "R3");
    tick(8'h00, "R3");
    tick(8'h00, "R3");
    tick(8'h02, "R3");
    xfer(1, 4'd3, 8'h02, "R10");
    tick(8'h02, "R10");

    // R4: L=0
    do_reset(3'd0);
    req(0, 4'd2, 8'h00, "R4");
    xfer(0, 4'd2, 8'h00, "R4");
    tick(8'h00, "R4");
    req(0, 4'd5, 8'h00, "R4");
    tick(8'h01, "R4");

    // R5: data-start coinciding with the pulse that ends the deadline, L=1
    do_reset(3'd1);
    req(0, 4'd6, 8'h00, "R5");
    tick(8'h00, "R5");
    step(1, 0, 0, 0, 1, 0, 4'd6, 8'h01, "R5");
    idle(8'h01, "R5");

    // R7 then R6
    do_reset(3'd5);
    req(0, 4'd1, 8'h00, "R7");
    req(0, 4'd2, 8'h00, "R7");
    req(1, 4'd7, 8'h00, "R7");
    xfer(1, 4'd7, 8'h00, "R7");
    xfer(0, 4'd1, 8'h00, "R7");
    xfer(0, 4'd2, 8'h00, "R7");
    req(0, 4'd3, 8'h00, "R6");
    req(0, 4'd4, 8'h00, "R6");
    xfer(0, 4'd4, 8'h04, "R6");
    idle(8'h04, "R6");

    // R8: empty data-start, also with same-cycle request
    do_reset(3'd5);
    xfer(1, 4'd0, 8'h20, "R8");
    step(0, 1, 0, 4'd1, 1, 0, 4'd1, 8'h30, "R8");
    idle(8'h30, "R8");

    // R9: fill to depth, one more is dropped, drain proves it
    do_reset(3'd5);
    for (int i = 0; i < DEPTH; i++) req(0, 4'(i), 8'h00, "R9");
    req(0, 4'd15, 8'h40, "R9");
    for (int i = 0; i < DEPTH; i++) xfer(0, 4'(i), 8'h40, "R9");
    xfer(0, 4'd15, 8'h50, "R9");

    // R11: lat_cfg=7 behaves as 5
    do_reset(3'd7);
    req(1, 4'd9, 8'h00, "R11");
    for (int i = 0; i < 5; i++) tick(8'h00, "R11");
    tick(8'h02, "R11");
    idle(8'h02, "R11");

    repeat (3) @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule